// File: doc/BRIEF.md
# Reconfigurable Pin Function Crossbar

This block sits between a bank of 24 general-purpose pins, arranged as three ports of eight, and the on-chip peripherals that may use them. Every pin owns a 5-bit function code held in a register. Software writes that register over a small write port and reads it back over a separate read port. The code decides what drives the pin. It can be one of 24 serial-interface signals, one of 6 timer capture/compare channels, nothing at all, or nothing with the pad isolated for analog use.

On the output side, each pin takes its value, output enable and open-drain attribute from the function it is mapped to. Serial functions decide the pin direction themselves. Timer functions and unmapped pins use the port direction bit. The data and clock functions of the two I2C-capable channels become open drain while that channel is in I2C mode. On the input side, each peripheral input receives the pad value of the pin mapped to it. When several pins map to the same function, the lowest-numbered pin wins. All routing is combinational from the registered codes.

Top module: `pin_func_xbar`

## Requirements
- R1: After reset, pins 0..23 read back the codes 25,26,27,28,29,18,17,19, 1,2,3,7,5,6,9,10, 11,13,14,15,22,21,23,30, in pin order.
- R2: A write with `reg_wr`=1 to address 0..23 stores `reg_wdata[4:0]`, so 0xFF reads back as 31. The new code is visible on `reg_rdata` and on the pins after the next rising clock edge. A write to address 24..31 changes no register, and reading those addresses returns 0.
- R3: Code 0 drives `pad_out`=0, with `pad_oe` equal to that pin's `port_dir` bit. A pin with code 0 feeds no peripheral input.
- R4: Codes 1..24 select serial signal k=code-1: `pad_out`=`ser_out[k]` and `pad_oe`=`ser_oe[k]`, and `port_dir` has no effect. Signals 0..15 are four 4-signal channels without I2C. Signals 16..23 are two 4-signal channels ordered data, clock-line, clock, enable.
- R5: Codes 17 and 18 while `i2c_mode[0]`=1, and codes 21 and 22 while `i2c_mode[1]`=1, give `pad_od`=1, `pad_out`=0 and `pad_oe`=`ser_oe[k]` AND NOT `ser_out[k]`. With that mode bit at 0, the same codes behave as R4.
- R6: Codes 25..30 select timer channel j=code-25: `pad_out`=`tmr_out[j]`, `pad_oe`=`port_dir` bit, and the pad value feeds `tmr_in[j]`.
- R7: Code 31 (analog) forces `pad_oe`=0, `pad_out`=0 and `pad_ien`=0. The pin feeds no peripheral input.
- R8: `ser_in[k]` and `tmr_in[j]` equal the `pad_in` of the lowest-numbered pin carrying the matching code, and 0 when no pin carries it.
- R9: `pad_ien`=1 for every code except 31, and `pad_od`=0 outside the R5 condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for a mapping register |
| reg_waddr | input | 5 | Pin index written |
| reg_wdata | input | 8 | Write data, low 5 bits kept |
| reg_raddr | input | 5 | Pin index read |
| reg_rdata | output | 5 | Code of the pin at reg_raddr |
| port_dir | input | 24 | Port direction bits for codes 0 and 25..30 |
| i2c_mode | input | 2 | I2C mode of the two open-drain-capable channels |
| ser_out | input | 24 | Serial peripheral output values |
| ser_oe | input | 24 | Serial peripheral output enables |
| ser_in | output | 24 | Pad values routed to serial inputs |
| tmr_out | input | 6 | Timer compare outputs |
| tmr_in | output | 6 | Pad values routed to timer capture inputs |
| pad_in | input | 24 | Pad input values |
| pad_out | output | 24 | Pad output values |
| pad_oe | output | 24 | Pad output enables |
| pad_od | output | 24 | Pad open-drain attribute |
| pad_ien | output | 24 | Pad input enables |

## Verification
Random code maps are applied with random peripheral and pad values. A map packed with few distinct codes exposes priority errors between pins that share a destination, while sparse maps exercise the zero default of unmapped destinations. Directed maps cover the following cases. Every pin on code 0 separates "no function" from a routed one. An analog pin holding the only instance of a code shows whether isolation blocks the input path. I2C codes with both mode values and both data levels separate open-drain release from a driven high. Writes of 0xFF and writes to addresses past pin 23 expose truncation and address decoding faults.

// File: rtl/pxbar_pkg.sv
// Shared constants, the function code type and code classification helpers
// for the pin function crossbar. Assumes 24 pins and a 5-bit code space.
package pxbar_pkg;
    localparam int PORT_CNT      = 3;
    localparam int PINS_PER_PORT = 8;
    localparam int PIN_CNT       = PORT_CNT * PINS_PER_PORT;
    localparam int CODE_W        = 5;
    localparam int ADDR_W        = 5;
    localparam int WDATA_W       = 8;
    localparam int SER_CNT       = 24;
    localparam int TMR_CNT       = 6;
    localparam int I2C_CH_CNT    = 2;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_NONE   = 5'd0;
    localparam code_t SER_BASE    = 5'd1;
    localparam code_t TMR_BASE    = 5'd25;
    localparam code_t CODE_ANALOG = 5'd31;
    localparam code_t I2C_BASE    = 5'd17;  // first code of first I2C-capable channel
    localparam int    CH_CODES    = 4;      // codes per serial channel

    // Reset code of each pin; the per-pin defaults are part of the behaviour.
    function automatic code_t default_code(input int pin);
        case (pin)
            0: return 5'd25;  1: return 5'd26;  2: return 5'd27;  3: return 5'd28;
            4: return 5'd29;  5: return 5'd18;  6: return 5'd17;  7: return 5'd19;
            8: return 5'd1;   9: return 5'd2;  10: return 5'd3;  11: return 5'd7;
            12: return 5'd5;  13: return 5'd6;  14: return 5'd9;  15: return 5'd10;
            16: return 5'd11; 17: return 5'd13; 18: return 5'd14; 19: return 5'd15;
            20: return 5'd22; 21: return 5'd21; 22: return 5'd23; 23: return 5'd30;
            default: return CODE_NONE;
        endcase
    endfunction

    // True for the data or clock-line code of an I2C-capable channel.
    function automatic logic is_i2c_line(input code_t c);
        logic hit;
        hit = 1'b0;
        for (int ch = 0; ch < I2C_CH_CNT; ch++) begin
            if (c == I2C_BASE + code_t'(ch * CH_CODES) ||
                c == I2C_BASE + code_t'(ch * CH_CODES + 1))
                hit = 1'b1;
        end
        return hit;
    endfunction

    // Channel number (0 or 1) of an I2C line code.
    function automatic logic i2c_chan(input code_t c);
        return (c >= I2C_BASE + code_t'(CH_CODES));
    endfunction
endpackage

// File: rtl/pxbar_regs.sv
// Mapping register file: one CODE_W-bit code per pin, loaded with the
// per-pin default on reset, written with truncation of the write data, read
// combinationally. Assumes synchronous active-low reset.
module pxbar_regs
    import pxbar_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [WDATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0]  raddr,
    output code_t              rdata,
    output code_t              map_o [PIN_CNT]
);
    code_t map_q [PIN_CNT];

    for (genvar i = 0; i < PIN_CNT; i++) begin : g_reg
        // Hold one pin's code: default on reset, low write bits on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[i] <= default_code(i);
            else if (wr && waddr == ADDR_W'(i))
                map_q[i] <= wdata[CODE_W-1:0];
        end

        assign map_o[i] = map_q[i];

        p_reset_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> map_q[i] == default_code(i));
        p_write_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && waddr == ADDR_W'(i)) |=> map_q[i] == $past(wdata[CODE_W-1:0]));
        p_no_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && waddr == ADDR_W'(i)) |=> $stable(map_q[i]));
    end

    // Read port: out-of-range addresses return zero.
    always_comb begin
        rdata = CODE_NONE;
        for (int p = 0; p < PIN_CNT; p++)
            if (raddr == ADDR_W'(p)) rdata = map_q[p];
    end
endmodule

// File: rtl/pxbar_out_mux.sv
// Output selection for one pin: picks value, enable, open-drain and input
// enable from the pin's code. Assumes codes 1..SER_CNT are serial signals,
// TMR_BASE.. are timer channels and CODE_ANALOG isolates the pad.
module pxbar_out_mux
    import pxbar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  code_t                 code,
    input  logic                  dir,
    input  logic [I2C_CH_CNT-1:0] i2c_mode,
    input  logic [SER_CNT-1:0]    ser_out,
    input  logic [SER_CNT-1:0]    ser_oe,
    input  logic [TMR_CNT-1:0]    tmr_out,
    output logic                  pad_out,
    output logic                  pad_oe,
    output logic                  pad_od,
    output logic                  pad_ien
);
    logic                  is_ser;
    logic                  is_tmr;
    logic [CODE_W-1:0]     sidx;
    logic [2:0]            tidx;
    logic                  od_now;

    assign is_ser = (code >= SER_BASE) && (code < SER_BASE + code_t'(SER_CNT));
    assign is_tmr = (code >= TMR_BASE) && (code < TMR_BASE + code_t'(TMR_CNT));
    assign sidx   = code - SER_BASE;
    assign tidx   = 3'(code - TMR_BASE);
    assign od_now = is_ser && is_i2c_line(code) && i2c_mode[i2c_chan(code)];

    // Select the pad controls from the function class of the code.
    always_comb begin
        pad_out = 1'b0;
        pad_oe  = dir;
        pad_od  = 1'b0;
        pad_ien = 1'b1;
        if (code == CODE_ANALOG) begin
            pad_oe  = 1'b0;
            pad_ien = 1'b0;
        end else if (od_now) begin
            pad_od = 1'b1;
            pad_oe = ser_oe[sidx] & ~ser_out[sidx];
        end else if (is_ser) begin
            pad_out = ser_out[sidx];
            pad_oe  = ser_oe[sidx];
        end else if (is_tmr) begin
            pad_out = tmr_out[tidx];
        end
    end

    p_analog_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_ANALOG) |-> (!pad_oe && !pad_ien && !pad_out));
    p_od_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pad_od |-> (!pad_out && is_i2c_line(code)));
    p_serial_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ser && !pad_od) |-> (pad_oe == ser_oe[sidx]));
endmodule

// File: rtl/pxbar_in_sel.sv
// Input routing for a contiguous range of destination codes: each
// destination receives the pad value of the lowest-numbered pin carrying its
// code, or 0 when none does. Assumes the analog code lies outside the range.
module pxbar_in_sel
    import pxbar_pkg::*;
#(
    parameter int    DEST_CNT  = 24,
    parameter code_t DEST_BASE = 5'd1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  code_t               map_i [PIN_CNT],
    input  logic [PIN_CNT-1:0]  pad_in,
    output logic [DEST_CNT-1:0] dest_in
);
    for (genvar d = 0; d < DEST_CNT; d++) begin : g_dest
        localparam code_t MY_CODE = DEST_BASE + code_t'(d);
        logic sel;

        // Scan from the top pin down so the lowest match is applied last.
        always_comb begin
            sel = 1'b0;
            for (int p = PIN_CNT - 1; p >= 0; p--)
                if (map_i[p] == MY_CODE) sel = pad_in[p];
        end

        assign dest_in[d] = sel;

        p_first_pin_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (map_i[0] == MY_CODE) |-> (dest_in[d] == pad_in[0]));
    end
endmodule

// File: rtl/pin_func_xbar.sv
// Top of the pin function crossbar: mapping registers, one output selector
// per pin and input routers for serial and timer destinations. Assumes the
// peripherals and pads sit outside; all routing is combinational from codes.
module pin_func_xbar
    import pxbar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [4:0]            reg_waddr,
    input  logic [7:0]            reg_wdata,
    input  logic [4:0]            reg_raddr,
    output logic [4:0]            reg_rdata,
    input  logic [23:0]           port_dir,
    input  logic [1:0]            i2c_mode,
    input  logic [23:0]           ser_out,
    input  logic [23:0]           ser_oe,
    output logic [23:0]           ser_in,
    input  logic [5:0]            tmr_out,
    output logic [5:0]            tmr_in,
    input  logic [23:0]           pad_in,
    output logic [23:0]           pad_out,
    output logic [23:0]           pad_oe,
    output logic [23:0]           pad_od,
    output logic [23:0]           pad_ien
);
    code_t map_w [PIN_CNT];

    pxbar_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .rdata (reg_rdata),
        .map_o (map_w)
    );

    for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
        pxbar_out_mux u_mux (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (map_w[p]),
            .dir      (port_dir[p]),
            .i2c_mode (i2c_mode),
            .ser_out  (ser_out),
            .ser_oe   (ser_oe),
            .tmr_out  (tmr_out),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p]),
            .pad_od   (pad_od[p]),
            .pad_ien  (pad_ien[p])
        );
    end

    pxbar_in_sel #(.DEST_CNT(SER_CNT), .DEST_BASE(SER_BASE)) u_ser_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .map_i   (map_w),
        .pad_in  (pad_in),
        .dest_in (ser_in)
    );

    pxbar_in_sel #(.DEST_CNT(TMR_CNT), .DEST_BASE(TMR_BASE)) u_tmr_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .map_i   (map_w),
        .pad_in  (pad_in),
        .dest_in (tmr_in)
    );
endmodule

// File: tb/tb_pin_func_xbar.sv
// Self-checking bench: directed corner cases plus seeded random maps, each
// compared with a bench model of the requirements.
module tb_pin_func_xbar;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_waddr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [4:0]  reg_raddr = '0;
    logic [4:0]  reg_rdata;
    logic [23:0] port_dir = '0;
    logic [1:0]  i2c_mode = '0;
    logic [23:0] ser_out = '0, ser_oe = '0, ser_in;
    logic [5:0]  tmr_out = '0, tmr_in;
    logic [23:0] pad_in = '0, pad_out, pad_oe, pad_od, pad_ien;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [4:0] mdl [24];

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_func_xbar dut (.*);

    function automatic logic [4:0] reset_code(input int p);
        int t [24] = '{25,26,27,28,29,18,17,19,1,2,3,7,5,6,9,10,11,13,14,15,22,21,23,30};
        return 5'(t[p]);
    endfunction

    function automatic bit od_case(input logic [4:0] c);
        return ((c == 17 || c == 18) && i2c_mode[0]) || ((c == 21 || c == 22) && i2c_mode[1]);
    endfunction

    function automatic string req_of(input logic [4:0] c);
        if (c == 0) return "R3";
        if (c == 31) return "R7";
        if (c >= 25) return "R6";
        if (od_case(c)) return "R5";
        return "R4";
    endfunction

    // Expected {out, oe, od, ien} for pin p.
    function automatic logic [3:0] exp_pin(input int p);
        logic [4:0] c;
        c = mdl[p];
        if (c == 0) return {1'b0, port_dir[p], 1'b0, 1'b1};
        if (c == 31) return 4'b0000;
        if (c >= 25) return {tmr_out[c-25], port_dir[p], 1'b0, 1'b1};
        if (od_case(c)) return {1'b0, ser_oe[c-1] & ~ser_out[c-1], 1'b1, 1'b1};
        return {ser_out[c-1], ser_oe[c-1], 1'b0, 1'b1};
    endfunction

    function automatic logic exp_dest(input int code);
        for (int p = 0; p < 24; p++)
            if (int'(mdl[p]) == code) return pad_in[p];
        return 1'b0;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_pins();
        logic [23:0] es;
        logic [5:0]  et;
        for (int p = 0; p < 24; p++)
            chk(req_of(mdl[p]), $sformatf("pin %0d code %0d", p, mdl[p]),
                32'({pad_out[p], pad_oe[p], pad_od[p], pad_ien[p]}), 32'(exp_pin(p)));
        for (int k = 0; k < 24; k++) es[k] = exp_dest(k + 1);
        for (int j = 0; j < 6; j++)  et[j] = exp_dest(j + 25);
        chk("R8", "ser_in", 32'(ser_in), 32'(es));
        chk("R8", "tmr_in", 32'(tmr_in), 32'(et));
    endtask

    task automatic check_regs(input string req);
        for (int a = 0; a < 32; a++) begin
            reg_raddr = 5'(a);
            #1;
            chk(req, $sformatf("readback %0d", a), 32'(reg_rdata), (a < 24) ? 32'(mdl[a]) : 32'd0);
        end
    endtask

    task automatic write_map(input int addr, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = 5'(addr); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        if (addr < 24) mdl[addr] = data[4:0];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < 24; p++) mdl[p] = reset_code(p);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset defaults, and their routing
        check_regs("R1");
        pad_in = 24'h5A3C96; ser_out = 24'hF0F0F0; ser_oe = 24'hFFFFFF;
        tmr_out = 6'h2B; port_dir = 24'h00FF0F; #1;
        check_pins();

        // R2: truncation of 0xFF to 31 and ignored out-of-range writes
        write_map(4, 8'hFF);
        #1; reg_raddr = 5'd4; #1;
        chk("R2", "0xFF readback", 32'(reg_rdata), 32'd31);
        write_map(24, 8'h03);
        write_map(31, 8'h07);
        check_regs("R2");

        // R7: analog pin holding the only copy of code 29 feeds nothing
        write_map(4, 8'h1F);
        pad_in = 24'hFFFFFF; #1;
        chk("R7", "tmr_in[4] from analog pin", 32'(tmr_in[4]), 32'd0);
        check_pins();

        // R3: all pins unmapped drive low and feed nothing
        for (int p = 0; p < 24; p++) write_map(p, 8'h00);
        port_dir = 24'hA5A5A5; #1;
        chk("R3", "pad_out all zero", 32'(pad_out), 32'd0);
        chk("R3", "pad_oe follows port_dir", 32'(pad_oe), 32'hA5A5A5);
        chk("R3", "ser_in none", 32'(ser_in), 32'd0);
        check_pins();

        // R8: several pins share code 3; the lowest-numbered one wins
        write_map(20, 8'h03); write_map(7, 8'h03); write_map(12, 8'h03);
        pad_in = 24'h000000; pad_in[7] = 1'b1; #1;
        chk("R8", "ser_in[2] from pin 7", 32'(ser_in[2]), 32'd1);
        pad_in = 24'hFFFFFF; pad_in[7] = 1'b0; #1;
        chk("R8", "ser_in[2] lowest pin low", 32'(ser_in[2]), 32'd0);
        check_pins();

        // R5: I2C lines open drain in mode, push-pull out of mode
        write_map(5, 8'd17); write_map(6, 8'd22);
        i2c_mode = 2'b11; ser_oe = 24'hFFFFFF; ser_out = '0; #1;
        chk("R5", "pin5 pulls low", 32'({pad_out[5], pad_oe[5], pad_od[5]}), 32'b011);
        ser_out[16] = 1'b1; ser_out[21] = 1'b1; #1;
        chk("R5", "pin5 releases", 32'({pad_out[5], pad_oe[5], pad_od[5]}), 32'b001);
        check_pins();
        i2c_mode = 2'b00; #1;
        chk("R5", "pin6 push-pull out of mode", 32'({pad_out[6], pad_oe[6], pad_od[6]}), 32'b110);
        check_pins();

        // R4/R6/R8/R9: random maps and random stimulus
        for (int it = 0; it < 400; it++) begin
            int nw;
            nw = int'($urandom_range(1, 4));
            for (int w = 0; w < nw; w++)
                write_map(int'($urandom_range(0, 31)),
                          ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                                      : 8'($urandom_range(0, 31)));
            port_dir = 24'($urandom); i2c_mode = 2'($urandom);
            ser_out  = 24'($urandom); ser_oe = 24'($urandom);
            tmr_out  = 6'($urandom);  pad_in = 24'($urandom);
            #1;
            check_pins();
            if (it % 50 == 0) check_regs("R2");
        end
        finish_run();
    end
endmodule